// File: doc/BRIEF.md
# Graphics DMA Byte Transfer Engine

This block is the slave side of a DMA path inside a graphics controller. A DMA read or DMA write command loads a start word address, a step direction and a line pitch. It also loads a byte count worked out from the command's word-count and line-count fields, and it raises a request line. An external DMA controller then answers with single-cycle acknowledge strobes, one per byte. On reads, the block fetches display-memory words and hands them out one byte at a time. On writes, it gathers bytes into words and stores them through a masked read-modify-write path that applies one of four logical operations.

The block uses a memory port with combinational read data. The address port always shows the current word address. A store is issued in the same cycle as the acknowledge that completes it, with a per-lane byte enable. Each memory access moves the word address by the selected direction and pitch, and the address wraps at 18 bits. When the last byte has been serviced, the request falls, the execute status clears, and a one-cycle pulse asks the drawing logic to reset its figure parameters.

Top module: `gdma_engine`

## Requirements
- R1: After reset, `drq`, `exec_busy`, `fig_reset`, `type_err`, `mem_wr_en` and `mem_rd_en` are 0 and `ack_rdata` is 0.
- R2: The transfer type comes from `cmd_type` (command bits 4:3: 0 = word, 1 = invalid, 2 = low byte, 3 = high byte) and the logical operation from `cmd_mode` (command bits 1:0). A `cmd_valid` pulse while idle sets `drq` and `exec_busy` from the next cycle and loads `cmd_addr` onto `mem_addr`.
- R3: A read command allows (words+1)*(lines+2) acknowledges. A write command allows (words+1)*(lines+1). `drq` stays high until the last of these has been taken.
- R4: A command that arrives while `exec_busy` is 1 is ignored. It changes neither the byte count nor the address.
- R5: On a type 0 read, an acknowledge taken with an even remaining count fetches the word at `mem_addr` and returns its low byte. An acknowledge with an odd remaining count returns the high byte of that held word without a memory access.
- R6: Type 2 and type 3 reads fetch a word on every acknowledge and return its low byte (type 2) or its high byte (type 3).
- R7: On a type 0 write, an even remaining count only latches the byte as the low half. An odd remaining count supplies the high half, and the word ANDed with `wr_mask` is written to both lanes.
- R8: Type 2 writes store the byte ANDed with `wr_mask[7:0]` in the low lane (`mem_wbe`=01). Type 3 writes store the byte ANDed with `wr_mask[15:8]` in the high lane (`mem_wbe`=10). Both write on every acknowledge.
- R9: The mode selects how the stored value is formed from the old word and the masked data: 0 replace, 1 XOR, 2 clear bits that are set in the data, 3 OR.
- R10: After each memory access the address moves by dx + dy*pitch, modulo 2^18. The steps for directions 0..7 are: 0 (0,+1), 1 (+1,+1), 2 (+1,0), 3 (+1,-1), 4 (0,-1), 5 (-1,-1), 6 (-1,0), 7 (-1,+1). An acknowledge without an access leaves the address unchanged.
- R11: On the final acknowledge, `drq` and `exec_busy` fall and `fig_reset` pulses for exactly one cycle. Acknowledges while idle have no effect: no memory write, no pulse.
- R12: A type 1 acknowledge returns 0 on reads, makes no memory access, pulses `type_err` for one cycle, and still counts one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = DMA write command, 0 = DMA read command |
| cmd_type | input | 2 | Transfer type (command bits 4:3) |
| cmd_mode | input | 2 | Logical operation (command bits 1:0) |
| cmd_words | input | CNT_W | Word count field |
| cmd_lines | input | LINE_W | Line count field |
| cmd_addr | input | AW | Start word address |
| cmd_dir | input | 3 | Step direction |
| cmd_pitch | input | PW | Words per display line |
| wr_mask | input | 16 | Write mask |
| ack_rd | input | 1 | Read acknowledge strobe |
| ack_wr | input | 1 | Write acknowledge strobe |
| ack_wdata | input | 8 | Byte supplied on a write acknowledge |
| ack_rdata | output | 8 | Byte returned for a read acknowledge |
| drq | output | 1 | DMA request, active high |
| exec_busy | output | 1 | DMA execute status |
| fig_reset | output | 1 | One-cycle figure-parameter reset pulse |
| type_err | output | 1 | One-cycle invalid-type pulse |
| mem_addr | output | AW | Current word address |
| mem_rd_en | output | 1 | Word fetch in this cycle |
| mem_rdata | input | 16 | Combinational read data at `mem_addr` |
| mem_wr_en | output | 1 | Word store in this cycle |
| mem_wbe | output | 2 | Byte-lane enables for the store |
| mem_wdata | output | 16 | Store data |

## Verification
A command strobe shows up on `drq`, `exec_busy` and `mem_addr` one edge later. A read acknowledge places its byte on `ack_rdata` at the edge that samples the strobe. A store appears on the memory port in the acknowledge cycle itself and lands in memory at that same edge. `fig_reset` and `type_err` are high only during the cycle that follows the acknowledge that caused them. The bench drives inputs on falling edges and queues each expected read byte when it raises the strobe. A monitor then compares the byte at the next falling edge, after exactly one register. Status, address and memory contents are sampled at that same falling edge, and the pulse outputs are sampled again one cycle later to confirm they have dropped.

// File: rtl/gdma_pkg.sv
package gdma_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        XT_WORD = 2'd0,
        XT_BAD  = 2'd1,
        XT_LOW  = 2'd2,
        XT_HIGH = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        OP_REPL = 2'd0,
        OP_XOR  = 2'd1,
        OP_CLR  = 2'd2,
        OP_SET  = 2'd3
    } wr_op_e;

    typedef struct packed {
        logic       is_write;
        xfer_kind_e kind;
        wr_op_e     op;
    } xfer_cfg_t;

    // Combine the old memory word with masked source data.
    function automatic logic [WORD_W-1:0] apply_op(
        input wr_op_e            op,
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] src_w
    );
        logic [WORD_W-1:0] r;
        case (op)
            OP_REPL: r = src_w;
            OP_XOR:  r = old_w ^ src_w;
            OP_CLR:  r = old_w & ~src_w;
            default: r = old_w | src_w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gdma_len_calc.sv
module gdma_len_calc #(
    parameter int CNT_W  = 14,
    parameter int LINE_W = 14,
    parameter int LEN_W  = CNT_W + LINE_W + 1
) (
    input  logic              is_write,
    input  logic [CNT_W-1:0]  words,
    input  logic [LINE_W-1:0] lines,
    output logic [LEN_W-1:0]  byte_len
);
    logic [LEN_W-1:0] word_term;
    logic [LEN_W-1:0] line_term;

    always_comb begin
        word_term = LEN_W'(words) + LEN_W'(1);
        // Reads cover one more line than writes.
        line_term = LEN_W'(lines) + (is_write ? LEN_W'(1) : LEN_W'(2));
        byte_len  = word_term * line_term;
    end
endmodule

// File: rtl/gdma_addr_gen.sv
module gdma_addr_gen #(
    parameter int AW = 18,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [2:0]    load_dir,
    input  logic [PW-1:0] load_pitch,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic [2:0]    dir_q;
    logic [PW-1:0] pitch_q;
    logic [AW-1:0] delta;

    function automatic logic [AW-1:0] step_of(input logic [2:0] d, input logic [PW-1:0] p);
        logic [AW-1:0] pos;
        logic [AW-1:0] neg;
        logic [AW-1:0] dx;
        logic [AW-1:0] dy;
        pos = AW'(p);
        neg = ~pos + AW'(1);
        dx  = '0;
        dy  = '0;
        case (d)
            3'd0: dy = pos;
            3'd1: begin dx = AW'(1); dy = pos; end
            3'd2: dx = AW'(1);
            3'd3: begin dx = AW'(1); dy = neg; end
            3'd4: dy = neg;
            3'd5: begin dx = '1; dy = neg; end
            3'd6: dx = '1;
            default: begin dx = '1; dy = pos; end
        endcase
        return dx + dy;
    endfunction

    assign delta = step_of(dir_q, pitch_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            dir_q   <= '0;
            pitch_q <= '0;
        end else if (load) begin
            addr    <= load_addr;
            dir_q   <= load_dir;
            pitch_q <= load_pitch;
        end else if (step) begin
            addr <= addr + delta;
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(addr)) else $error("address moved without access"); // R10
endmodule

// File: rtl/gdma_lane_unit.sv
module gdma_lane_unit
    import gdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  xfer_cfg_t         cfg,
    input  logic              busy,
    input  logic              len_odd,
    input  logic              ack_rd,
    input  logic              ack_wr,
    input  logic [BYTE_W-1:0] ack_wdata,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] ack_rdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [1:0]        mem_wbe,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              access,
    output logic              bad_type
);
    logic [WORD_W-1:0] hold_q;
    logic              rd_take;
    logic              wr_take;
    logic              latch_lo;
    logic [WORD_W-1:0] src_w;

    assign rd_take = busy && ack_rd;
    assign wr_take = busy && ack_wr;

    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        latch_lo  = 1'b0;
        mem_wbe   = 2'b00;
        src_w     = '0;
        case (cfg.kind)
            XT_WORD: begin
                mem_rd_en = rd_take && !len_odd;
                mem_wr_en = wr_take && len_odd;
                latch_lo  = wr_take && !len_odd;
                mem_wbe   = mem_wr_en ? 2'b11 : 2'b00;
                src_w     = {ack_wdata, hold_q[BYTE_W-1:0]} & wr_mask;
            end
            XT_LOW: begin
                mem_rd_en = rd_take;
                mem_wr_en = wr_take;
                mem_wbe   = mem_wr_en ? 2'b01 : 2'b00;
                src_w     = {{BYTE_W{1'b0}}, ack_wdata & wr_mask[BYTE_W-1:0]};
            end
            XT_HIGH: begin
                mem_rd_en = rd_take;
                mem_wr_en = wr_take;
                mem_wbe   = mem_wr_en ? 2'b10 : 2'b00;
                src_w     = {ack_wdata & wr_mask[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
            end
            default: ;
        endcase
        mem_wdata = apply_op(cfg.op, mem_rdata, src_w);
        access    = mem_rd_en || mem_wr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            ack_rdata <= '0;
            bad_type  <= 1'b0;
        end else begin
            bad_type <= (rd_take || wr_take) && (cfg.kind == XT_BAD);
            if (mem_rd_en)
                hold_q <= mem_rdata;
            else if (latch_lo)
                hold_q[BYTE_W-1:0] <= ack_wdata;
            if (rd_take) begin
                case (cfg.kind)
                    XT_WORD: ack_rdata <= len_odd ? hold_q[WORD_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];
                    XT_LOW:  ack_rdata <= mem_rdata[BYTE_W-1:0];
                    XT_HIGH: ack_rdata <= mem_rdata[WORD_W-1:BYTE_W];
                    default: ack_rdata <= '0;
                endcase
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ack_rd && ack_wr)) else $error("both strobes high"); // R5
    AST_NO_STORE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        ack_rd |-> !mem_wr_en) else $error("store during read acknowledge"); // R6
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_wr_en && !mem_rd_en)) else $error("access while idle"); // R11
    AST_BAD_TYPE_ZERO: assert property (@(posedge clk) disable iff (rst)
        bad_type && $past(ack_rd) |-> ack_rdata == '0) else $error("invalid type returned data"); // R12
endmodule

// File: rtl/gdma_engine.sv
module gdma_engine
    import gdma_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int LINE_W = 14,
    parameter int AW     = 18,
    parameter int PW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [1:0]        cmd_type,
    input  logic [1:0]        cmd_mode,
    input  logic [CNT_W-1:0]  cmd_words,
    input  logic [LINE_W-1:0] cmd_lines,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [2:0]        cmd_dir,
    input  logic [PW-1:0]     cmd_pitch,
    input  logic [15:0]       wr_mask,
    input  logic              ack_rd,
    input  logic              ack_wr,
    input  logic [7:0]        ack_wdata,
    output logic [7:0]        ack_rdata,
    output logic              drq,
    output logic              exec_busy,
    output logic              fig_reset,
    output logic              type_err,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd_en,
    input  logic [15:0]       mem_rdata,
    output logic              mem_wr_en,
    output logic [1:0]        mem_wbe,
    output logic [15:0]       mem_wdata
);
    localparam int LEN_W = CNT_W + LINE_W + 1;

    xfer_cfg_t        cfg_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] new_len;
    logic             start;
    logic             take;
    logic             access;

    assign start = cmd_valid && !exec_busy;
    assign take  = exec_busy && (ack_rd || ack_wr);

    gdma_len_calc #(.CNT_W(CNT_W), .LINE_W(LINE_W), .LEN_W(LEN_W)) u_len (
        .is_write (cmd_write),
        .words    (cmd_words),
        .lines    (cmd_lines),
        .byte_len (new_len)
    );

    gdma_addr_gen #(.AW(AW), .PW(PW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .load_addr  (cmd_addr),
        .load_dir   (cmd_dir),
        .load_pitch (cmd_pitch),
        .step       (access),
        .addr       (mem_addr)
    );

    gdma_lane_unit u_lane (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .busy      (exec_busy),
        .len_odd   (len_q[0]),
        .ack_rd    (ack_rd),
        .ack_wr    (ack_wr),
        .ack_wdata (ack_wdata),
        .wr_mask   (wr_mask),
        .mem_rdata (mem_rdata),
        .ack_rdata (ack_rdata),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_wbe   (mem_wbe),
        .mem_wdata (mem_wdata),
        .access    (access),
        .bad_type  (type_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '{is_write: 1'b0, kind: XT_WORD, op: OP_REPL};
            len_q     <= '0;
            exec_busy <= 1'b0;
            drq       <= 1'b0;
            fig_reset <= 1'b0;
        end else begin
            fig_reset <= 1'b0;
            if (start) begin
                cfg_q     <= '{is_write: cmd_write, kind: xfer_kind_e'(cmd_type), op: wr_op_e'(cmd_mode)};
                len_q     <= new_len;
                exec_busy <= 1'b1;
                drq       <= 1'b1;
            end else if (take) begin
                len_q <= len_q - LEN_W'(1);
                if (len_q == LEN_W'(1)) begin
                    exec_busy <= 1'b0;
                    drq       <= 1'b0;
                    fig_reset <= 1'b1;
                end
            end
        end
    end

    AST_BUSY_HAS_LEN: assert property (@(posedge clk) disable iff (rst)
        exec_busy |-> len_q != '0) else $error("busy with empty count"); // R3
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        take |=> len_q == $past(len_q) - LEN_W'(1)) else $error("count did not drop"); // R3
    AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (exec_busy && cmd_valid && !ack_rd && !ack_wr) |=> $stable(len_q) && $stable(mem_addr)) else $error("command taken while busy"); // R4
    AST_LAST_DROPS: assert property (@(posedge clk) disable iff (rst)
        (take && len_q == LEN_W'(1)) |=> (!drq && !exec_busy && fig_reset)) else $error("final byte did not stop"); // R11
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        fig_reset |=> !fig_reset) else $error("reset pulse too long"); // R11
    AST_DRQ_STATUS: assert property (@(posedge clk) disable iff (rst)
        drq == exec_busy) else $error("request and status disagree"); // R2
endmodule

// File: tb/sim_gdma_engine.sv
module sim_gdma_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [1:0]  cmd_type = '0;
    logic [1:0]  cmd_mode = '0;
    logic [13:0] cmd_words = '0;
    logic [13:0] cmd_lines = '0;
    logic [17:0] cmd_addr = '0;
    logic [2:0]  cmd_dir = '0;
    logic [7:0]  cmd_pitch = '0;
    logic [15:0] wr_mask = 16'hFFFF;
    logic        ack_rd = 1'b0;
    logic        ack_wr = 1'b0;
    logic [7:0]  ack_wdata = '0;
    logic [7:0]  ack_rdata;
    logic        drq, exec_busy, fig_reset, type_err;
    logic [17:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_rdata, mem_wdata;
    logic [1:0]  mem_wbe;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mem [0:1023];
    logic [7:0]  exp_q [$];
    logic        rd_seen = 1'b0;

    always #10 clk = ~clk;

    gdma_engine u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_type(cmd_type), .cmd_mode(cmd_mode), .cmd_words(cmd_words),
        .cmd_lines(cmd_lines), .cmd_addr(cmd_addr), .cmd_dir(cmd_dir),
        .cmd_pitch(cmd_pitch), .wr_mask(wr_mask), .ack_rd(ack_rd), .ack_wr(ack_wr),
        .ack_wdata(ack_wdata), .ack_rdata(ack_rdata), .drq(drq), .exec_busy(exec_busy),
        .fig_reset(fig_reset), .type_err(type_err), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
        .mem_wbe(mem_wbe), .mem_wdata(mem_wdata)
    );

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (mem_wr_en) begin
            if (mem_wbe[0]) mem[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
            if (mem_wbe[1]) mem[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
        end
        rd_seen <= ack_rd;
    end

    function automatic logic [15:0] init_val(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b ^ 8'h5A, b};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compares each read byte one edge after its strobe.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected read byte", 32'(ack_rdata), 32'h0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(ack_rdata == e, "R5/R6/R12 read byte", 32'(ack_rdata), 32'(e));
            end
        end
    end

    task automatic issue(input bit wr, input logic [1:0] ty, input logic [1:0] md,
                         input int words, input int lines, input int addr,
                         input logic [2:0] dir, input int pitch);
        cmd_valid = 1'b1; cmd_write = wr; cmd_type = ty; cmd_mode = md;
        cmd_words = 14'(words); cmd_lines = 14'(lines); cmd_addr = 18'(addr);
        cmd_dir = dir; cmd_pitch = 8'(pitch);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd_ack(input logic [7:0] e);
        exp_q.push_back(e);
        ack_rd = 1'b1;
        @(negedge clk);
        ack_rd = 1'b0;
    endtask

    task automatic wr_ack(input logic [7:0] b);
        ack_wdata = b;
        ack_wr = 1'b1;
        @(negedge clk);
        ack_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!drq && !exec_busy && !fig_reset && !type_err, "R1 idle outputs", 32'({drq, exec_busy, fig_reset, type_err}), 32'h0);
        check(ack_rdata == 8'h00 && !mem_wr_en && !mem_rd_en, "R1 data and memory", 32'(ack_rdata), 32'h0);

        // Type 0 read: (1+1)*(0+2) = 4 bytes, direction 2 steps +1.
        issue(1'b0, 2'd0, 2'd0, 1, 0, 16, 3'd2, 40);
        check(drq && exec_busy, "R2 start raises request", 32'({drq, exec_busy}), 32'h3);
        check(mem_addr == 18'd16, "R2 address loaded", 32'(mem_addr), 32'd16);
        rd_ack(init_val(16)[7:0]);
        rd_ack(init_val(16)[15:8]);
        check(mem_addr == 18'd17, "R5 odd count makes no access", 32'(mem_addr), 32'd17);
        rd_ack(init_val(17)[7:0]);
        check(drq, "R3 read count not yet done", 32'(drq), 32'h1);
        rd_ack(init_val(17)[15:8]);
        check(!drq && !exec_busy && fig_reset, "R11 stop after last byte", 32'({drq, exec_busy, fig_reset}), 32'h1);
        check(mem_addr == 18'd18, "R10 step +1", 32'(mem_addr), 32'd18);
        @(negedge clk);
        check(!fig_reset, "R11 pulse lasts one cycle", 32'(fig_reset), 32'h0);

        // Type 3 read, direction 4 (-pitch), wraps below zero.
        issue(1'b0, 2'd3, 2'd0, 0, 0, 10, 3'd4, 40);
        rd_ack(init_val(10)[15:8]);
        check(mem_addr == 18'h3FFE2, "R10 wrap at 18 bits", 32'(mem_addr), 32'h3FFE2);
        rd_ack(init_val(18'h3FFE2 & 10'h3FF)[15:8]);
        check(!drq, "R3 read length two", 32'(drq), 32'h0);

        // Type 2 read, direction 0 (+pitch), 1*3 bytes.
        issue(1'b0, 2'd2, 2'd0, 0, 1, 100, 3'd0, 40);
        rd_ack(init_val(100)[7:0]);
        rd_ack(init_val(140)[7:0]);
        rd_ack(init_val(180)[7:0]);
        check(!drq && mem_addr == 18'd220, "R6 low bytes along pitch", 32'(mem_addr), 32'd220);

        // Type 0 write with mask 0F0F, replace.
        wr_mask = 16'h0F0F;
        issue(1'b1, 2'd0, 2'd0, 0, 1, 200, 3'd2, 40);
        wr_ack(8'h12);
        check(mem[200] == init_val(200) && drq, "R7 low half only latched", 32'(mem[200]), 32'(init_val(200)));
        wr_ack(8'h34);
        check(mem[200] == 16'h0402, "R7 masked word stored", 32'(mem[200]), 32'h0402);
        check(!drq && mem_addr == 18'd201, "R3 write length two", 32'(mem_addr), 32'd201);
        wr_mask = 16'hFFFF;

        // Byte-lane writes with logical operations.
        issue(1'b1, 2'd2, 2'd1, 0, 0, 300, 3'd2, 40);
        wr_ack(8'hFF);
        v = init_val(300) ^ 16'h00FF;
        check(mem[300] == v && !drq, "R8 R9 low lane xor", 32'(mem[300]), 32'(v));
        issue(1'b1, 2'd3, 2'd3, 0, 0, 301, 3'd2, 40);
        wr_ack(8'h81);
        v = init_val(301) | 16'h8100;
        check(mem[301] == v, "R8 R9 high lane or", 32'(mem[301]), 32'(v));
        issue(1'b1, 2'd3, 2'd2, 0, 0, 302, 3'd2, 40);
        wr_ack(8'hF0);
        v = init_val(302) & 16'h0FFF;
        check(mem[302] == v, "R9 clear bits", 32'(mem[302]), 32'(v));
        wr_mask = 16'h00FF;
        issue(1'b1, 2'd3, 2'd0, 0, 0, 303, 3'd2, 40);
        wr_ack(8'hAB);
        v = {8'h00, init_val(303)[7:0]};
        check(mem[303] == v, "R8 high lane mask", 32'(mem[303]), 32'(v));
        wr_mask = 16'hFFFF;

        // Write length (1+1)*(1+1) = 4 using set with zero data.
        issue(1'b1, 2'd2, 2'd3, 1, 1, 500, 3'd2, 40);
        for (int k = 0; k < 3; k++) wr_ack(8'h00);
        check(drq, "R3 write count not yet done", 32'(drq), 32'h1);
        wr_ack(8'h00);
        check(!drq, "R3 write count done", 32'(drq), 32'h0);

        // Command while busy is ignored.
        issue(1'b0, 2'd2, 2'd0, 0, 0, 400, 3'd2, 40);
        issue(1'b1, 2'd0, 2'd0, 5, 5, 700, 3'd0, 40);
        check(mem_addr == 18'd400, "R4 address kept", 32'(mem_addr), 32'd400);
        rd_ack(init_val(400)[7:0]);
        rd_ack(init_val(401)[7:0]);
        check(!drq, "R4 count kept", 32'(drq), 32'h0);

        // Invalid type.
        issue(1'b0, 2'd1, 2'd0, 0, 0, 600, 3'd2, 40);
        rd_ack(8'h00);
        check(type_err && drq && mem_addr == 18'd600, "R12 error pulse, no access", 32'({type_err, drq}), 32'h3);
        rd_ack(8'h00);
        check(!drq, "R12 still counted", 32'(drq), 32'h0);
        @(negedge clk);
        check(!type_err, "R12 pulse ends", 32'(type_err), 32'h0);

        // Acknowledge while idle.
        v = mem[mem_addr[9:0]];
        wr_ack(8'h5A);
        check(mem[mem_addr[9:0]] == v && !drq && !fig_reset, "R11 idle ack ignored", 32'(mem[mem_addr[9:0]]), 32'(v));

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R5 all read bytes seen", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule